// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Controller

This block gives software control over 28 general-purpose pins through eight word registers on a simple 32-bit bus. Each pin can be an input or an output. Its output latch is changed only by writing ones to a set register or to a clear register, so two agents can update different pins without a read-modify-write. The current state of every pin can be read at any time, whatever its direction. Pin inputs pass through a two-stage synchronizer before any logic sees them.

Each pin has its own rising-edge enable and falling-edge enable. An enabled edge sets a sticky status bit, which stays set until software writes a one to it. Pins 0 to 10 each drive a dedicated interrupt line from their status bit. Pins 11 to 27 share one interrupt line, which is the OR of their status bits. A separate storage register selects an alternate function per pin and is presented on an output port for an external multiplexer.

The bus is single-cycle. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_word` while `bus_sel` is high and `bus_wr` is low. Word index n corresponds to byte offset 4·n.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Word index 1 (byte 0x04) holds the direction, 4 (0x10) the rising enables, 5 (0x14) the falling enables and 7 (0x1C) the alternate-function select; each reads back what was last written, and the alternate-function value appears on `alt_sel`.
- R2: Bits 31..28 of every register read as zero, and writes to those bits have no effect.
- R3: A write to word 2 (0x08) sets each output latch bit whose data bit is 1. Zero bits leave the latch unchanged, and word 2 reads as zero.
- R4: A write to word 3 (0x0C) clears each output latch bit whose data bit is 1. Zero bits leave the latch unchanged, and word 3 reads as zero.
- R5: `pin_oe` equals the direction register, where 1 means output and 0 means input.
- R6: Word 0 (0x00) returns the synchronized pin state regardless of direction. A change on `pin_in` becomes visible after two clock edges.
- R7: A rising edge sets its status bit only when that pin's rising enable is 1. A pin with neither enable set never records an edge.
- R8: A falling edge sets its status bit only when that pin's falling enable is 1. With both enables set, either edge is recorded.
- R9: Status bits in word 6 (0x18) are sticky. Writing 1 clears a bit, writing 0 leaves it, and writing all ones clears every pending bit.
- R10: If an edge is detected in the same cycle that software writes 1 to clear that status bit, the bit stays set.
- R11: `irq_pin[i]` equals status bit i for i = 0..10. `irq_shared` is the OR of status bits 11..27.
- R12: After reset, the output latch, direction, both enables, the status and the alternate-function register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| pin_in | input | 28 | Asynchronous pin input levels |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable per pin |
| alt_sel | output | 28 | Alternate-function select |
| irq_pin | output | 11 | Dedicated interrupts, pins 0..10 |
| irq_shared | output | 1 | Combined interrupt, pins 11..27 |

## Verification
A status bit that is stuck, or that is lost in a collision between an edge and a clear, shows on the matching interrupt line. It also shows on a word-6 read, three clock edges after the pin moves. A corrupted output latch or direction bit shows on `pin_out` or `pin_oe` at the next clock edge after the write. A wrong synchronizer depth shifts the cycle in which word 0 and the status register change. The collision case is therefore driven with exact cycle alignment, so that the edge and the clear land on the same clock edge.

// File: rtl/gpioedge_pkg.sv
package gpioedge_pkg;

    localparam int NPIN   = 28;
    localparam int BUS_W  = 32;
    localparam int WORD_W = 3;
    localparam int NDED   = 11;
    localparam int SYNC_N = 2;

    typedef enum logic [WORD_W-1:0] {
        W_LEVEL = 3'd0,
        W_DIR   = 3'd1,
        W_SET   = 3'd2,
        W_CLR   = 3'd3,
        W_RISE  = 3'd4,
        W_FALL  = 3'd5,
        W_STAT  = 3'd6,
        W_ALT   = 3'd7
    } word_e;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic stat;
        logic alt;
    } wstrb_t;

    function automatic wstrb_t decode_write(logic sel, logic wr, word_e w);
        wstrb_t s;
        logic   go;
        go     = sel && wr;
        s.dir  = go && (w == W_DIR);
        s.set  = go && (w == W_SET);
        s.clr  = go && (w == W_CLR);
        s.rise = go && (w == W_RISE);
        s.fall = go && (w == W_FALL);
        s.stat = go && (w == W_STAT);
        s.alt  = go && (w == W_ALT);
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        chain[0] <= d;
        for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gpioedge_pkg::*;
#(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  wstrb_t       strb,
    input  logic [W-1:0] wd,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q,
    output logic [W-1:0] alt_q
);

    localparam int NRW = 4;

    logic [NRW-1:0] rw_we;
    logic [W-1:0]   rw_q [NRW];

    assign rw_we = {strb.alt, strb.fall, strb.rise, strb.dir};

    generate
        for (genvar g = 0; g < NRW; g++) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst) begin
                    rw_q[g] <= '0;
                end else if (rw_we[g]) begin
                    rw_q[g] <= wd;
                end
            end
        end
    endgenerate

    assign dir_q  = rw_q[0];
    assign rise_q = rw_q[1];
    assign fall_q = rw_q[2];
    assign alt_q  = rw_q[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (strb.set) begin
            out_q <= out_q | wd;
        end else if (strb.clr) begin
            out_q <= out_q & ~wd;
        end
    end

    AST_OUT_SET: assert property (@(posedge clk) disable iff (rst)
        strb.set |=> ((out_q & $past(wd)) == $past(wd)))
        else $error("set strobe did not raise latch bits"); // R3
    AST_OUT_CLR: assert property (@(posedge clk) disable iff (rst)
        strb.clr |=> ((out_q & $past(wd)) == '0))
        else $error("clear strobe did not drop latch bits"); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!strb.set && !strb.clr) |=> $stable(out_q))
        else $error("latch moved without strobe"); // R3

endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat
);

    logic [W-1:0] prev_q;
    logic [W-1:0] det;
    logic [W-1:0] clr_eff;
    logic [W-1:0] stat_q;

    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    assign det     = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_eff) | det;
        end
    end

    assign stat = stat_q;

    AST_NEW_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat_q & ~$past(stat_q) & ~$past(det)) == '0))
        else $error("status set without enabled edge"); // R7
    AST_DROP_NEEDS_CLR: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((~stat_q & $past(stat_q) & ~$past(clr_eff)) == '0))
        else $error("status dropped without clear"); // R9
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(det) & ~stat_q) == '0))
        else $error("detected edge lost"); // R10

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpioedge_pkg::*;
#(
    parameter int NP  = gpioedge_pkg::NPIN,
    parameter int BW  = gpioedge_pkg::BUS_W,
    parameter int WW  = gpioedge_pkg::WORD_W,
    parameter int ND  = gpioedge_pkg::NDED,
    parameter int SYN = gpioedge_pkg::SYNC_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [WW-1:0] bus_word,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic [NP-1:0] pin_in,
    output logic [NP-1:0] pin_out,
    output logic [NP-1:0] pin_oe,
    output logic [NP-1:0] alt_sel,
    output logic [ND-1:0] irq_pin,
    output logic          irq_shared
);

    localparam int PADW = BW - NP;

    wstrb_t        strb;
    logic [NP-1:0] wd;
    logic [NP-1:0] lvl;
    logic [NP-1:0] dir_q, rise_q, fall_q, alt_q, out_q, stat;
    logic [NP-1:0] rd_sel;
    logic          wdata_unused;

    assign strb         = decode_write(bus_sel, bus_wr, word_e'(bus_word));
    assign wd           = bus_wdata[NP-1:0];
    assign wdata_unused = ^bus_wdata[BW-1:NP];

    gpio_in_sync #(.W(NP), .STAGES(SYN)) i_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (lvl)
    );

    gpio_ctl_regs #(.W(NP)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .strb   (strb),
        .wd     (wd),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .rise_q (rise_q),
        .fall_q (fall_q),
        .alt_q  (alt_q)
    );

    gpio_edge_stat #(.W(NP)) i_edge (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .clr_wr   (strb.stat),
        .clr_mask (wd),
        .stat     (stat)
    );

    always_comb begin
        case (word_e'(bus_word))
            W_LEVEL: rd_sel = lvl;
            W_DIR:   rd_sel = dir_q;
            W_RISE:  rd_sel = rise_q;
            W_FALL:  rd_sel = fall_q;
            W_STAT:  rd_sel = stat;
            W_ALT:   rd_sel = alt_q;
            default: rd_sel = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? {{PADW{1'b0}}, rd_sel} : '0;

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign alt_sel = alt_q;

    generate
        for (genvar i = 0; i < ND; i++) begin : g_irq
            assign irq_pin[i] = stat[i];
        end
    endgenerate
    assign irq_shared = |stat[NP-1:ND];

    generate
        if (SYN == 2) begin : g_lat_chk
            AST_LEVEL_LAT: assert property (@(posedge clk) disable iff (rst)
                lvl == $past(pin_in, 2))
                else $error("level latency wrong"); // R6
        end
    endgenerate

endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe, alt_sel;
    logic [10:0] irq_pin;
    logic        irq_shared;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_word   (bus_word),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .alt_sel    (alt_sel),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );

    typedef struct packed {
        logic [2:0]  wa;
        logic [31:0] wv;
        logic [2:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 32'hFFFF_FFFF, 3'd1, 32'h0FFF_FFFF},
        '{3'd4, 32'h0A5A_5A5A, 3'd4, 32'h0A5A_5A5A},
        '{3'd5, 32'hF123_4567, 3'd5, 32'h0123_4567},
        '{3'd7, 32'h0BAD_CAFE, 3'd7, 32'h0BAD_CAFE},
        '{3'd2, 32'h0000_0000, 3'd2, 32'h0000_0000},
        '{3'd3, 32'h0000_0000, 3'd3, 32'h0000_0000},
        '{3'd1, 32'h0000_0000, 3'd1, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset values of every register and output
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), r);
            chk("R12 reset read", r, 32'h0);
        end
        chk("R12 pin_out", {4'h0, pin_out}, 32'h0);
        chk("R12 pin_oe", {4'h0, pin_oe}, 32'h0);
        chk("R12 irq", {20'h0, irq_shared, irq_pin}, 32'h0);

        // R1 R2 R3 R4: register table walk
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v].wa, VEC[v].wv);
            rd(VEC[v].ra, r);
            chk("R1/R2 table readback", r, VEC[v].exp);
        end
        chk("R1 alt_sel port", {4'h0, alt_sel}, 32'h0BAD_CAFE);

        do_reset();
        rd(3'd7, r);
        chk("R12 alt after reset", r, 32'h0);

        // R3 R4: set and clear strobes
        wr(3'd2, 32'hF000_00F0);
        chk("R3 set", {4'h0, pin_out}, 32'h0000_00F0);
        wr(3'd2, 32'h0000_0001);
        chk("R3 set keeps others", {4'h0, pin_out}, 32'h0000_00F1);
        rd(3'd2, r);
        chk("R3 set reads zero", r, 32'h0);
        wr(3'd3, 32'h0000_0030);
        chk("R4 clear", {4'h0, pin_out}, 32'h0000_00C1);
        wr(3'd3, 32'h0000_0000);
        chk("R4 zero clear no effect", {4'h0, pin_out}, 32'h0000_00C1);

        // R5: direction drives output enable
        wr(3'd1, 32'h0F0F_0F0F);
        chk("R5 pin_oe", {4'h0, pin_oe}, 32'h0F0F_0F0F);

        // R6: level read, independent of direction; R7 no enables, no record
        pin_in = 28'hABC_DEF1;
        @(negedge clk);
        @(negedge clk);
        rd(3'd0, r);
        chk("R6 level after two edges", r, 32'h0ABC_DEF1);
        settle();
        rd(3'd6, r);
        chk("R7 no enable no status", r, 32'h0);
        pin_in = '0;
        settle();
        rd(3'd0, r);
        chk("R6 level back to zero", r, 32'h0);

        // R7 R8 R11: enables and interrupt lines
        wr(3'd4, 32'h0000_1021);
        wr(3'd5, 32'h0000_1002);
        pin_in = 28'h000_1003;
        settle();
        rd(3'd6, r);
        chk("R7 rising recorded", r, 32'h0000_1001);
        chk("R11 dedicated lines", {21'h0, irq_pin}, 32'h001);
        chk("R11 shared line", {31'h0, irq_shared}, 32'h1);
        pin_in = '0;
        settle();
        rd(3'd6, r);
        chk("R8 falling recorded", r, 32'h0000_1003);

        // R9: write-one-to-clear
        wr(3'd6, 32'h0000_0001);
        rd(3'd6, r);
        chk("R9 single clear", r, 32'h0000_1002);
        chk("R11 dedicated after clear", {21'h0, irq_pin}, 32'h002);
        wr(3'd6, 32'h0000_0000);
        rd(3'd6, r);
        chk("R9 zero write keeps", r, 32'h0000_1002);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, r);
        chk("R9 clear all", r, 32'h0);
        chk("R11 shared low", {31'h0, irq_shared}, 32'h0);

        // R10: edge and clear in the same cycle
        pin_in = 28'h000_0020;
        settle();
        pin_in = '0;
        settle();
        rd(3'd6, r);
        chk("R10 precondition", r, 32'h0000_0020);
        @(negedge clk);
        pin_in = 28'h000_0020;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 3'd6; bus_wdata = 32'h0000_0020;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(3'd6, r);
        chk("R10 edge wins over clear", r, 32'h0000_0020);
        wr(3'd6, 32'h0000_0020);
        rd(3'd6, r);
        chk("R9 clear without edge", r, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule